// File: doc/BRIEF.md
# Four-Way Set-Associative Cache Tag Lookup

This block is the tag-and-state path of a small physically addressed cache. It holds 8 sets of 4 lines, each line 64 bytes, for 2 KB in all. A requester presents a byte address. The block reads the set named by the middle address bits and compares the upper bits against the four stored tags of that set in parallel. It answers with hit or miss, the way involved, and the addressed byte of the line.

On a miss the block stops taking lookups. It raises a line-fill request toward the next memory level with the line-aligned address and waits for the whole 64-byte line to come back. It then writes that line into a victim way of the set. An invalid way is used first; once every way is valid, a per-set rotating pointer chooses the victim. The answer to the request comes after the install and reports a miss together with the way that received the line.

Two further outputs serve diagnosis. A sticky error flag rises if a lookup ever matches more than one way. A per-set mask records which sets have taken a fill since it was last cleared, so an access pattern that leaves some sets idle can be seen directly.

Top module: `sa4_cache_lookup`

## Requirements
- R1: Address bits [5:0] are the byte offset, bits [8:6] the set index and bits [31:9] the tag; the fill request address equals the request address with bits [5:0] forced to zero.
- R2: A request accepted while req_ready_o is high whose tag matches a valid way of its set gives rsp_valid_o high for one cycle right after the accepting edge, with rsp_hit_o=1, rsp_way_o the matching way number (0 to 3), and rsp_data_o the line byte at the offset.
- R3: On a miss, fill_req_valid_o rises right after the accepting edge and holds with a stable address until fill_req_ready_i is seen high at an edge; from the accept until the fill response is taken, req_ready_o and rsp_valid_o stay low.
- R4: A fill response (fill_rsp_valid_i high after the request handshake, byte b of the line at bits [8b+7:8b]) installs the line; right after that edge rsp_valid_o is high with rsp_hit_o=0, rsp_way_o the victim way and rsp_data_o the returned byte at the offset, and a later access to that line hits.
- R5: multi_hit_o rises, and stays high until reset, if a lookup matches more than one way; with distinct tags per set it stays low.
- R6: While a set has an invalid way, the victim is the lowest-numbered invalid way.
- R7: Each set has a 2-bit pointer, zero after reset, that steps by one (wrapping 3 to 0) on every fill into that set; when all four ways are valid, the pointer value is the victim.
- R8: touched_o bit s is set by each fill into set s and all bits are cleared by touched_clear_i; a 128-byte stride over eight fresh lines gives touched_o = 8'h55.
- R9: After reset all ways are invalid, req_ready_o is high, rsp_valid_o, fill_req_valid_o and multi_hit_o are low and touched_o is zero.
- R10: Consecutive 64-byte lines map to consecutive sets, so eight sequential fresh lines set touched_o bits 0 through 7 in that order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Lookup request present |
| req_ready_o | output | 1 | Block can accept a lookup |
| req_addr_i | input | 32 | Byte address of the lookup |
| rsp_valid_o | output | 1 | Lookup answer valid, one cycle |
| rsp_hit_o | output | 1 | 1 on hit, 0 when answered after a fill |
| rsp_way_o | output | 2 | Way that hit or received the line |
| rsp_data_o | output | 8 | Addressed byte of the line |
| multi_hit_o | output | 1 | Sticky error: more than one way matched |
| fill_req_valid_o | output | 1 | Line fill requested |
| fill_req_ready_i | input | 1 | Lower level takes the fill request |
| fill_req_addr_o | output | 32 | Line-aligned fill address |
| fill_rsp_valid_i | input | 1 | Fill line returned |
| fill_rsp_data_i | input | 512 | Returned line, byte b at bits [8b+7:8b] |
| touched_clear_i | input | 1 | Clear the touched-set mask |
| touched_o | output | 8 | Sets filled since last clear |

## Verification
A hit answers one edge after the accepting edge, a miss raises its fill request after that same edge, and the miss answer appears one edge after the edge that takes the fill response; the touched mask changes at the install edge. The bench drives inputs on falling edges and reads outputs on the next falling edge, half a cycle after the register that produces each result, so every check looks at exactly one registered update. During a miss it deliberately delays both the request handshake and the response by extra cycles and checks that nothing is answered or accepted meanwhile.

// File: rtl/sa4_cache_pkg.sv
package sa4_cache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_FILL_REQ  = 2'd1,
    ST_FILL_WAIT = 2'd2
  } ctrl_state_e;
endpackage

// File: rtl/sa4_tag_match.sv
module sa4_tag_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 23,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]            valid_i,
  input  logic [WAYS-1:0][TAG_W-1:0] tags_i,
  input  logic [TAG_W-1:0]           tag_i,
  output logic                       hit_o,
  output logic [WAY_W-1:0]           way_o,
  output logic                       multi_o
);
  logic [WAYS-1:0] match;
  logic [WAY_W:0]  cnt;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = valid_i[w] && (tags_i[w] == tag_i);
  end

  always_comb begin
    way_o = '0;
    cnt   = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) way_o = WAY_W'(w);
      cnt = cnt + {{WAY_W{1'b0}}, match[w]};
    end
  end

  assign hit_o   = |match;
  assign multi_o = cnt > 1;
endmodule

// File: rtl/sa4_victim_sel.sv
module sa4_victim_sel #(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]  valid_i,
  input  logic [WAY_W-1:0] rr_i,
  output logic [WAY_W-1:0] victim_o
);
  always_comb begin
    logic found;
    found    = 1'b0;
    victim_o = rr_i;
    for (int w = 0; w < WAYS; w++) begin
      if (!found && !valid_i[w]) begin
        victim_o = WAY_W'(w);
        found    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sa4_touch_track.sv
module sa4_touch_track #(
  parameter int SETS = 8,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fill_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             clear_i,
  output logic [SETS-1:0]  mask_o
);
  logic [SETS-1:0] set_vec;

  always_comb begin
    set_vec = '0;
    if (fill_i) set_vec[idx_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_o <= '0;
    else         mask_o <= (clear_i ? '0 : mask_o) | set_vec;
  end
endmodule

// File: rtl/sa4_cache_lookup.sv
module sa4_cache_lookup
  import sa4_cache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int SETS       = 8,
  parameter int WAYS       = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      req_valid_i,
  output logic                      req_ready_o,
  input  logic [ADDR_W-1:0]         req_addr_i,
  output logic                      rsp_valid_o,
  output logic                      rsp_hit_o,
  output logic [$clog2(WAYS)-1:0]   rsp_way_o,
  output logic [7:0]                rsp_data_o,
  output logic                      multi_hit_o,
  output logic                      fill_req_valid_o,
  input  logic                      fill_req_ready_i,
  output logic [ADDR_W-1:0]         fill_req_addr_o,
  input  logic                      fill_rsp_valid_i,
  input  logic [LINE_BYTES*8-1:0]   fill_rsp_data_i,
  input  logic                      touched_clear_i,
  output logic [SETS-1:0]           touched_o
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(SETS);
  localparam int WAY_W  = $clog2(WAYS);
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int LINE_W = LINE_BYTES * 8;
  localparam int LINES  = SETS * WAYS;

  ctrl_state_e state_q;

  logic [WAYS-1:0][TAG_W-1:0] tag_q   [SETS];
  logic [WAYS-1:0]            valid_q [SETS];
  logic [WAY_W-1:0]           rr_q    [SETS];
  logic [LINE_W-1:0]          data_q  [LINES];
  logic [ADDR_W-1:0]          miss_addr_q;

  // lookup side
  logic [OFF_W-1:0] lk_off;
  logic [IDX_W-1:0] lk_idx;
  logic [TAG_W-1:0] lk_tag;
  logic             lk_hit, lk_multi, lookup;
  logic [WAY_W-1:0] lk_way;
  logic [LINE_W-1:0] lk_line;

  assign lk_off = req_addr_i[OFF_W-1:0];
  assign lk_idx = req_addr_i[OFF_W +: IDX_W];
  assign lk_tag = req_addr_i[ADDR_W-1 -: TAG_W];
  assign lookup = req_valid_i && (state_q == ST_IDLE);

  sa4_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
    .valid_i (valid_q[lk_idx]),
    .tags_i  (tag_q[lk_idx]),
    .tag_i   (lk_tag),
    .hit_o   (lk_hit),
    .way_o   (lk_way),
    .multi_o (lk_multi)
  );

  assign lk_line = data_q[{lk_idx, lk_way}];

  // miss side
  logic [OFF_W-1:0] ms_off;
  logic [IDX_W-1:0] ms_idx;
  logic [TAG_W-1:0] ms_tag;
  logic [WAY_W-1:0] victim;
  logic             fill_fire;

  assign ms_off    = miss_addr_q[OFF_W-1:0];
  assign ms_idx    = miss_addr_q[OFF_W +: IDX_W];
  assign ms_tag    = miss_addr_q[ADDR_W-1 -: TAG_W];
  assign fill_fire = (state_q == ST_FILL_WAIT) && fill_rsp_valid_i;

  sa4_victim_sel #(.WAYS(WAYS)) u_victim (
    .valid_i  (valid_q[ms_idx]),
    .rr_i     (rr_q[ms_idx]),
    .victim_o (victim)
  );

  sa4_touch_track #(.SETS(SETS)) u_touch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fill_i  (fill_fire),
    .idx_i   (ms_idx),
    .clear_i (touched_clear_i),
    .mask_o  (touched_o)
  );

  assign req_ready_o      = (state_q == ST_IDLE);
  assign fill_req_valid_o = (state_q == ST_FILL_REQ);
  assign fill_req_addr_o  = {miss_addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      miss_addr_q <= '0;
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_way_o   <= '0;
      rsp_data_o  <= '0;
      multi_hit_o <= 1'b0;
      for (int s = 0; s < SETS; s++) begin
        tag_q[s]   <= '0;
        valid_q[s] <= '0;
        rr_q[s]    <= '0;
      end
    end else begin
      rsp_valid_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (lookup) begin
            multi_hit_o <= multi_hit_o | lk_multi;
            if (lk_hit) begin
              rsp_valid_o <= 1'b1;
              rsp_hit_o   <= 1'b1;
              rsp_way_o   <= lk_way;
              rsp_data_o  <= lk_line[{lk_off, 3'b000} +: 8];
            end else begin
              miss_addr_q <= req_addr_i;
              state_q     <= ST_FILL_REQ;
            end
          end
        end
        ST_FILL_REQ: begin
          if (fill_req_ready_i) state_q <= ST_FILL_WAIT;
        end
        ST_FILL_WAIT: begin
          if (fill_rsp_valid_i) begin
            valid_q[ms_idx][victim] <= 1'b1;
            tag_q[ms_idx][victim]   <= ms_tag;
            rr_q[ms_idx]            <= rr_q[ms_idx] + 1'b1;
            rsp_valid_o             <= 1'b1;
            rsp_hit_o               <= 1'b0;
            rsp_way_o               <= victim;
            rsp_data_o              <= fill_rsp_data_i[{ms_off, 3'b000} +: 8];
            state_q                 <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // line storage, no reset
  always_ff @(posedge clk_i) begin
    if (fill_fire) data_q[{ms_idx, victim}] <= fill_rsp_data_i;
  end
endmodule

// File: rtl/sa4_cache_lookup_chk.sv
module sa4_cache_lookup_chk #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int SETS       = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic              rsp_valid_o,
  input logic              multi_hit_o,
  input logic              fill_req_valid_o,
  input logic              fill_req_ready_i,
  input logic [ADDR_W-1:0] fill_req_addr_o,
  input logic              touched_clear_i,
  input logic [SETS-1:0]   touched_o
);
  localparam int OFF_W = $clog2(LINE_BYTES);

  AST_FILL_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_req_valid_o |-> (fill_req_addr_o[OFF_W-1:0] == '0)); // R1

  AST_FILL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_req_valid_o && !fill_req_ready_i) |=> (fill_req_valid_o && $stable(fill_req_addr_o))); // R3

  AST_STALL_NO_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_req_valid_o |-> (!req_ready_o && !rsp_valid_o)); // R3

  AST_NO_MULTI_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !multi_hit_o); // R5

  AST_TOUCH_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !touched_clear_i |=> ((touched_o & $past(touched_o)) == $past(touched_o))); // R8

  AST_RSP_AFTER_FILL_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_req_valid_o |=> !rsp_valid_o); // R4
endmodule

bind sa4_cache_lookup sa4_cache_lookup_chk #(
  .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .SETS(SETS)
) u_chk (.*);

// File: tb/sa4_cache_lookup_tb_top.sv
module sa4_cache_lookup_tb_top;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         req_valid_i = 1'b0;
  logic         req_ready_o;
  logic [31:0]  req_addr_i = '0;
  logic         rsp_valid_o, rsp_hit_o, multi_hit_o;
  logic [1:0]   rsp_way_o;
  logic [7:0]   rsp_data_o;
  logic         fill_req_valid_o;
  logic         fill_req_ready_i = 1'b0;
  logic [31:0]  fill_req_addr_o;
  logic         fill_rsp_valid_i = 1'b0;
  logic [511:0] fill_rsp_data_i = '0;
  logic         touched_clear_i = 1'b0;
  logic [7:0]   touched_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  sa4_cache_lookup dut_i (.*);

  // {addr, expected hit, expected way}
  localparam int NVEC = 13;
  localparam logic [34:0] VEC [NVEC] = '{
    {32'h0000_0000, 1'b0, 2'd0},
    {32'h0000_0005, 1'b1, 2'd0},
    {32'h0000_0040, 1'b0, 2'd0},
    {32'h0000_0200, 1'b0, 2'd1},
    {32'h0000_0400, 1'b0, 2'd2},
    {32'h0000_0600, 1'b0, 2'd3},
    {32'h0000_0210, 1'b1, 2'd1},
    {32'h0000_0800, 1'b0, 2'd0},
    {32'h0000_0000, 1'b0, 2'd1},
    {32'h0000_0830, 1'b1, 2'd0},
    {32'h0000_063C, 1'b1, 2'd3},
    {32'h0000_0200, 1'b0, 2'd2},
    {32'h0000_007F, 1'b1, 2'd0}
  };

  function automatic logic [7:0] mem_byte(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'hA5;
  endfunction

  function automatic logic [511:0] mem_line(input logic [31:0] base);
    logic [511:0] l;
    for (int b = 0; b < 64; b++) l[b*8 +: 8] = mem_byte(base | 32'(b));
    return l;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input logic [31:0] a, output logic hit, output logic [1:0] way);
    logic [31:0] al;
    al = {a[31:6], 6'b0};
    @(negedge clk_i);
    chk(req_ready_o, "R3 ready before request", 64'(req_ready_o), 1);
    req_valid_i = 1'b1;
    req_addr_i  = a;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    if (rsp_valid_o) begin
      hit = rsp_hit_o;
      way = rsp_way_o;
      chk(rsp_data_o == mem_byte(a), "R2 hit data", 64'(rsp_data_o), 64'(mem_byte(a)));
    end else begin
      chk(fill_req_valid_o, "R3 fill request raised", 64'(fill_req_valid_o), 1);
      chk(fill_req_addr_o == al, "R1 fill address aligned", 64'(fill_req_addr_o), 64'(al));
      chk(!req_ready_o, "R3 stall during miss", 64'(req_ready_o), 0);
      @(negedge clk_i);
      chk(fill_req_valid_o && fill_req_addr_o == al, "R3 fill request held",
          64'(fill_req_addr_o), 64'(al));
      fill_req_ready_i = 1'b1;
      @(negedge clk_i);
      fill_req_ready_i = 1'b0;
      chk(!fill_req_valid_o, "R3 fill request dropped after handshake", 64'(fill_req_valid_o), 0);
      repeat (2) begin
        @(negedge clk_i);
        chk(!rsp_valid_o && !req_ready_o, "R3 no answer before fill",
            64'({rsp_valid_o, req_ready_o}), 0);
      end
      fill_rsp_valid_i = 1'b1;
      fill_rsp_data_i  = mem_line(al);
      @(negedge clk_i);
      fill_rsp_valid_i = 1'b0;
      chk(rsp_valid_o, "R4 answer after fill", 64'(rsp_valid_o), 1);
      chk(rsp_data_o == mem_byte(a), "R4 fill data", 64'(rsp_data_o), 64'(mem_byte(a)));
      hit = rsp_hit_o;
      way = rsp_way_o;
    end
    chk(!multi_hit_o, "R5 no multi-match", 64'(multi_hit_o), 0);
  endtask

  task automatic check_reset_state();
    chk(req_ready_o, "R9 ready after reset", 64'(req_ready_o), 1);
    chk(!rsp_valid_o && !fill_req_valid_o && !multi_hit_o, "R9 outputs low after reset",
        64'({rsp_valid_o, fill_req_valid_o, multi_hit_o}), 0);
    chk(touched_o == 8'h00, "R9 touched mask clear", 64'(touched_o), 0);
  endtask

  task automatic clear_touch();
    @(negedge clk_i);
    touched_clear_i = 1'b1;
    @(negedge clk_i);
    touched_clear_i = 1'b0;
    chk(touched_o == 8'h00, "R8 clear", 64'(touched_o), 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic h;
    logic [1:0] w;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_reset_state();

    // table: R1 R2 R4 R6 R7
    for (int i = 0; i < NVEC; i++) begin
      access(VEC[i][34:3], h, w);
      chk(h == VEC[i][2], $sformatf("R2/R4 hit flag vec %0d", i), 64'(h), 64'(VEC[i][2]));
      chk(w == VEC[i][1:0], $sformatf("R6/R7 way vec %0d", i), 64'(w), 64'(VEC[i][1:0]));
    end
    chk(touched_o == 8'h03, "R8 mask after table", 64'(touched_o), 64'h03);

    // 128-byte stride: even sets only
    clear_touch();
    for (int k = 0; k < 8; k++) begin
      access(32'h0001_0000 + 32'(k * 128), h, w);
      chk(!h, "R8 stride fresh line misses", 64'(h), 0);
    end
    chk(touched_o == 8'h55, "R8 stride 128 fills even sets", 64'(touched_o), 64'h55);

    // sequential lines: successive sets
    clear_touch();
    for (int k = 0; k < 8; k++) begin
      access(32'h0002_0000 + 32'(k * 64), h, w);
      chk(touched_o == 8'((16'h1 << (k + 1)) - 1), "R10 sequential sets",
          64'(touched_o), 64'((16'h1 << (k + 1)) - 1));
    end

    // reset in the middle invalidates all ways
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_reset_state();
    access(32'h0000_0000, h, w);
    chk(!h && w == 2'd0, "R9 line gone after reset, R6 way 0", 64'({h, w}), 0);
    access(32'h0000_0003, h, w);
    chk(h && w == 2'd0, "R4 refilled line hits", 64'({h, w}), 64'h4);
    chk(touched_o == 8'h01, "R8 mask after refill", 64'(touched_o), 64'h01);

    finish_run();
  end
endmodule